// File: doc/BRIEF.md
# Partitioned Fully-Associative Translation Buffer

This block holds a small, fully associative set of address translations. Each entry's tag holds four things: an aligned virtual or real page address, a page-size code, a partition number and a context number. A flag marks the entry as real or virtual. The data word of each entry is carried opaquely, apart from its size code and lock bit. A lookup compares one request address against every entry in the same cycle. It returns a hit flag, the index of the hit and the stored data word.

Translations enter through an insert port. The caller either names a target index or lets the block choose a victim. Before the write, the block drops every existing entry that overlaps the new page in the same address space. A demap port removes one of three things: a single page, every page of a context, or every unlocked page of a partition. A readback port returns the packed tag word and the data word of any entry, and returns all ones for an empty slot. A per-entry used vector tracks recent use and is output as `used_bits`.

Top module: `ptlb_array`

## Requirements
- R1: After reset every entry is invalid, every used bit is clear and the replacement pointer is zero.
- R2: A lookup hits an entry when all of these hold: the entry is valid, its real flag and partition equal the request's, its context equals the request's (compared only when the request is virtual), and the request address with the entry's offset bits cleared equals the stored page. Size code c covers 2^(13+3c) bytes. The hit flag, the lowest hit index and that entry's data word appear in the same cycle.
- R3: An insert stores the page address aligned down to its size. Data-word bits 2:0 hold the size code and bit 6 holds the lock bit. The tag readback has these fields: partition in bits 63:61, real flag in bit 60, zero in bit 59, inverted size code in bits 58:56, page address in bits 55:13 and context in bits 12:0. The data readback returns the stored word.
- R4: An insert first invalidates every valid entry with the same real flag and partition whose range overlaps the new page. For virtual entries the context must also match.
- R5: An insert with the explicit flag writes the given index. Otherwise it writes the lowest-numbered entry that is invalid after the overlap step.
- R6: When no entry is free, the victim is found by scanning from pointer+1, wrapping, and skipping locked entries; the chosen index then becomes the pointer. If all entries are locked, entry N-1 is written and the pointer is kept.
- R7: An insert or a non-probe lookup hit sets the touched entry's used bit. When that makes every used bit set, all used bits other than the touched one are cleared. Invalidation clears an entry's used bit.
- R8: A lookup marked as a probe leaves the used bits unchanged.
- R9: Demap code 0 invalidates the entry that a lookup with the demap fields would hit.
- R10: Demap code 1 invalidates every valid entry whose partition and context match, whatever its real flag or lock.
- R11: Demap code 2 invalidates every unlocked valid entry of the partition, and locked entries stay. Code 3 has no effect.
- R12: Reading the tag or the data word of an invalid entry returns all ones.
- R13: If insert and demap arrive in the same cycle, the insert is done and the demap is ignored. A lookup updates used bits only in cycles with neither command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert command |
| ins_explicit | input | 1 | Use ins_index as the target |
| ins_index | input | IDX_W | Explicit target index |
| ins_va | input | VA_W | Page address (any offset) |
| ins_part | input | 3 | Partition number |
| ins_ctx | input | 13 | Context number |
| ins_phys | input | 1 | Real (untranslated) entry flag |
| ins_pte | input | 64 | Data word (size in 2:0, lock in 6) |
| lk_valid | input | 1 | Lookup request |
| lk_probe | input | 1 | Probe lookup, no used-bit update |
| lk_va | input | VA_W | Lookup address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_phys | input | 1 | Lookup is real |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Lowest hitting index |
| lk_pte | output | 64 | Data word of hit entry, zero on miss |
| dm_valid | input | 1 | Demap command |
| dm_kind | input | 2 | 0 page, 1 context, 2 partition, 3 none |
| dm_va | input | VA_W | Demap page address |
| dm_part | input | 3 | Demap partition |
| dm_ctx | input | 13 | Demap context |
| dm_phys | input | 1 | Demap real flag (page kind) |
| rd_index | input | IDX_W | Readback index |
| rd_tag | output | 64 | Packed tag of entry |
| rd_pte | output | 64 | Data word of entry |
| used_bits | output | N | Used bit per entry |

## Verification
The assertions check several rules on every cycle. A lookup hit always points at a valid entry. The used vector never becomes full and never marks an invalid entry. Probe lookups never change it. A partition demap never drops a locked entry. An explicit insert always leaves its target valid. When every entry is valid and locked, the victim is the last index. Empty slots always read back as all ones. Other behaviour shows only in the bench's scenarios, because the result depends on history: that the pointer advances past locked entries, that overlap invalidation frees the very slot that is then reused, that the used vector is cleared down to one bit at the point it fills, that a large page's mask covers its whole span, and that an insert takes precedence over a demap in the same cycle.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int WORD_W       = 64;
  localparam int PG_SHIFT     = 13;
  localparam int SZ_STEP      = 3;
  localparam int CTX_W        = 13;
  localparam int PART_W       = 3;
  localparam int SZ_W         = 3;
  localparam int PTE_LOCK_BIT = 6;
  localparam int TAG_PART_LSB = 61;
  localparam int TAG_PHYS_BIT = 60;
  localparam int TAG_SZ_LSB   = 56;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    DM_PAGE = 2'd0,
    DM_CTX  = 2'd1,
    DM_ALL  = 2'd2,
    DM_NONE = 2'd3
  } dm_kind_e;

  // Offset bits covered by a page of the given size code.
  function automatic word_t span_mask(input logic [SZ_W-1:0] code);
    word_t one;
    one = 64'd1;
    return (one << (PG_SHIFT + SZ_STEP * int'(code))) - one;
  endfunction

  function automatic logic page_hit(input word_t page, input word_t addr,
                                    input word_t mask);
    return (addr & ~mask) == page;
  endfunction

  // Two aligned power-of-two ranges meet when they agree above the larger mask.
  function automatic logic ranges_meet(input word_t pa, input word_t ma,
                                       input word_t pb, input word_t mb);
    word_t m;
    m = ma | mb;
    return (pa & ~m) == (pb & ~m);
  endfunction

  function automatic word_t pack_tag(input word_t page,
                                     input logic [PART_W-1:0] part,
                                     input logic phys,
                                     input logic [SZ_W-1:0] code,
                                     input logic [CTX_W-1:0] ctx);
    word_t t;
    t = '0;
    t[TAG_PART_LSB +: PART_W] = part;
    t[TAG_PHYS_BIT]           = phys;
    t[TAG_SZ_LSB +: SZ_W]     = ~code;
    t[TAG_SZ_LSB-1:PG_SHIFT]  = page[TAG_SZ_LSB-1:PG_SHIFT];
    t[CTX_W-1:0]              = ctx;
    return t;
  endfunction
endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam
  import ptlb_pkg::*;
#(
  parameter int N    = 16,
  parameter int VA_W = 40
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0]        lock,
  input  logic [N-1:0]        phys,
  input  logic [VA_W-1:0]     page [N],
  input  logic [SZ_W-1:0]     code [N],
  input  logic [PART_W-1:0]   part [N],
  input  logic [CTX_W-1:0]    ctx  [N],
  input  logic [VA_W-1:0]     lk_va,
  input  logic [PART_W-1:0]   lk_part,
  input  logic [CTX_W-1:0]    lk_ctx,
  input  logic                lk_phys,
  input  logic [VA_W-1:0]     dm_va,
  input  logic [PART_W-1:0]   dm_part,
  input  logic [CTX_W-1:0]    dm_ctx,
  input  logic                dm_phys,
  input  word_t               in_page,
  input  word_t               in_mask,
  input  logic [PART_W-1:0]   in_part,
  input  logic [CTX_W-1:0]    in_ctx,
  input  logic                in_phys,
  output logic [N-1:0]        lk_vec,
  output logic [N-1:0]        pg_vec,
  output logic [N-1:0]        cx_vec,
  output logic [N-1:0]        al_vec,
  output logic [N-1:0]        ov_vec
);
  localparam int PAD = WORD_W - VA_W;

  word_t lk_w, dm_w;
  assign lk_w = {{PAD{1'b0}}, lk_va};
  assign dm_w = {{PAD{1'b0}}, dm_va};

  for (genvar i = 0; i < N; i++) begin : g_ent
    word_t pg_i, mk_i;
    logic  lk_space, dm_space, in_space;
    assign pg_i = {{PAD{1'b0}}, page[i]};
    assign mk_i = span_mask(code[i]);
    assign lk_space = valid[i] && (phys[i] == lk_phys) && (part[i] == lk_part) &&
                      (lk_phys || (ctx[i] == lk_ctx));
    assign dm_space = valid[i] && (phys[i] == dm_phys) && (part[i] == dm_part) &&
                      (dm_phys || (ctx[i] == dm_ctx));
    assign in_space = valid[i] && (phys[i] == in_phys) && (part[i] == in_part) &&
                      (in_phys || (ctx[i] == in_ctx));
    assign lk_vec[i] = lk_space && page_hit(pg_i, lk_w, mk_i);
    assign pg_vec[i] = dm_space && page_hit(pg_i, dm_w, mk_i);
    assign cx_vec[i] = valid[i] && (part[i] == dm_part) && (ctx[i] == dm_ctx);
    assign al_vec[i] = valid[i] && !lock[i] && (part[i] == dm_part);
    assign ov_vec[i] = in_space && ranges_meet(pg_i, mk_i, in_page, in_mask);
  end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     free_n,
  input  logic [N-1:0]     lock,
  input  logic [IDX_W-1:0] last,
  input  logic             explicit_en,
  input  logic [IDX_W-1:0] explicit_idx,
  output logic [IDX_W-1:0] victim,
  output logic             from_scan
);
  logic             free_found, scan_found;
  logic [IDX_W-1:0] free_idx, scan_idx;

  // Lowest slot left empty (after overlap removal).
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!free_n[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  // Rotating scan from last+1, the last slot itself excluded.
  always_comb begin
    scan_found = 1'b0;
    scan_idx   = '0;
    for (int k = N - 1; k >= 1; k--) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (!lock[idx]) begin
        scan_found = 1'b1;
        scan_idx   = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    if (explicit_en)     victim = explicit_idx;
    else if (free_found) victim = free_idx;
    else if (scan_found) victim = scan_idx;
    else                 victim = IDX_W'(N - 1);
  end

  assign from_scan = !explicit_en && !free_found && scan_found;
endmodule

// File: rtl/ptlb_nru.sv
module ptlb_nru #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     used_q,
  input  logic [N-1:0]     clear,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [N-1:0]     used_d
);
  logic [N-1:0] hot, kept, merged;
  logic         full;

  assign hot    = touch_en ? ({{(N-1){1'b0}}, 1'b1} << touch_idx) : '0;
  assign kept   = used_q & ~clear;
  assign merged = kept | hot;
  assign full   = touch_en && (&merged);
  assign used_d = full ? hot : merged;
endmodule

// File: rtl/ptlb_array.sv
module ptlb_array
  import ptlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VA_W  = 40,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic               ins_explicit,
  input  logic [IDX_W-1:0]   ins_index,
  input  logic [VA_W-1:0]    ins_va,
  input  logic [2:0]         ins_part,
  input  logic [12:0]        ins_ctx,
  input  logic               ins_phys,
  input  logic [63:0]        ins_pte,
  input  logic               lk_valid,
  input  logic               lk_probe,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [2:0]         lk_part,
  input  logic [12:0]        lk_ctx,
  input  logic               lk_phys,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [63:0]        lk_pte,
  input  logic               dm_valid,
  input  logic [1:0]         dm_kind,
  input  logic [VA_W-1:0]    dm_va,
  input  logic [2:0]         dm_part,
  input  logic [12:0]        dm_ctx,
  input  logic               dm_phys,
  input  logic [IDX_W-1:0]   rd_index,
  output logic [63:0]        rd_tag,
  output logic [63:0]        rd_pte,
  output logic [N-1:0]       used_bits
);
  localparam int PAD = WORD_W - VA_W;

  // Entry state
  logic [N-1:0]        valid_q, used_q, phys_q;
  logic [IDX_W-1:0]    last_q;
  logic [VA_W-1:0]     page_q [N];
  logic [PART_W-1:0]   part_q [N];
  logic [CTX_W-1:0]    ctx_q  [N];
  word_t               pte_q  [N];
  logic [SZ_W-1:0]     code_w [N];
  logic [N-1:0]        lock_vec;

  for (genvar i = 0; i < N; i++) begin : g_fields
    assign code_w[i]   = pte_q[i][SZ_W-1:0];
    assign lock_vec[i] = pte_q[i][PTE_LOCK_BIT];
  end

  // Insert address shaping
  word_t            in_mask, in_page_w;
  logic [VA_W-1:0]  in_page;
  assign in_mask   = span_mask(ins_pte[SZ_W-1:0]);
  assign in_page_w = {{PAD{1'b0}}, ins_va} & ~in_mask;
  assign in_page   = in_page_w[VA_W-1:0];

  // Associative compare
  logic [N-1:0] lk_vec, pg_vec, cx_vec, al_vec, ov_vec;

  ptlb_cam #(.N(N), .VA_W(VA_W)) u_cam (
    .valid   (valid_q),
    .lock    (lock_vec),
    .phys    (phys_q),
    .page    (page_q),
    .code    (code_w),
    .part    (part_q),
    .ctx     (ctx_q),
    .lk_va   (lk_va),
    .lk_part (lk_part),
    .lk_ctx  (lk_ctx),
    .lk_phys (lk_phys),
    .dm_va   (dm_va),
    .dm_part (dm_part),
    .dm_ctx  (dm_ctx),
    .dm_phys (dm_phys),
    .in_page (in_page_w),
    .in_mask (in_mask),
    .in_part (ins_part),
    .in_ctx  (ins_ctx),
    .in_phys (ins_phys),
    .lk_vec  (lk_vec),
    .pg_vec  (pg_vec),
    .cx_vec  (cx_vec),
    .al_vec  (al_vec),
    .ov_vec  (ov_vec)
  );

  // Lookup: lowest matching index wins
  logic             lk_any;
  logic [IDX_W-1:0] lk_first;
  always_comb begin
    lk_any   = 1'b0;
    lk_first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_vec[i]) begin
        lk_any   = 1'b1;
        lk_first = IDX_W'(i);
      end
    end
  end

  assign lk_hit = lk_valid && lk_any;
  assign lk_idx = lk_first;
  assign lk_pte = lk_hit ? pte_q[lk_first] : '0;

  // Command arbitration: insert, then demap, then lookup used update
  logic         dm_fire, lk_touch;
  logic [N-1:0] kill_vec, valid_left;
  assign dm_fire  = dm_valid && !ins_valid;
  assign lk_touch = lk_hit && !lk_probe && !ins_valid && !dm_valid;

  always_comb begin
    kill_vec = '0;
    if (ins_valid) begin
      kill_vec = ov_vec;
    end else if (dm_fire) begin
      case (dm_kind_e'(dm_kind))
        DM_PAGE: kill_vec = pg_vec;
        DM_CTX:  kill_vec = cx_vec;
        DM_ALL:  kill_vec = al_vec;
        default: kill_vec = '0;
      endcase
    end
  end

  assign valid_left = valid_q & ~kill_vec;

  // Victim choice
  logic [IDX_W-1:0] victim_idx;
  logic             from_scan;
  ptlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .free_n       (valid_left),
    .lock         (lock_vec),
    .last         (last_q),
    .explicit_en  (ins_explicit),
    .explicit_idx (ins_index),
    .victim       (victim_idx),
    .from_scan    (from_scan)
  );

  // Used bits
  logic [N-1:0]     used_d;
  logic [IDX_W-1:0] touch_idx;
  assign touch_idx = ins_valid ? victim_idx : lk_first;

  ptlb_nru #(.N(N), .IDX_W(IDX_W)) u_nru (
    .used_q    (used_q),
    .clear     (kill_vec),
    .touch_en  (ins_valid || lk_touch),
    .touch_idx (touch_idx),
    .used_d    (used_d)
  );

  logic [N-1:0] write_hot;
  assign write_hot = ins_valid ? ({{(N-1){1'b0}}, 1'b1} << victim_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      last_q  <= '0;
    end else begin
      valid_q <= valid_left | write_hot;
      used_q  <= used_d;
      if (ins_valid && from_scan) last_q <= victim_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      page_q[victim_idx] <= in_page;
      part_q[victim_idx] <= ins_part;
      ctx_q[victim_idx]  <= ins_ctx;
      phys_q[victim_idx] <= ins_phys;
      pte_q[victim_idx]  <= ins_pte;
    end
  end

  // Indexed readback
  logic rd_ok;
  assign rd_ok  = (int'(rd_index) < N) && valid_q[rd_index];
  assign rd_tag = rd_ok ? pack_tag({{PAD{1'b0}}, page_q[rd_index]}, part_q[rd_index],
                                   phys_q[rd_index], code_w[rd_index], ctx_q[rd_index])
                        : '1;
  assign rd_pte = rd_ok ? pte_q[rd_index] : '1;

  assign used_bits = used_q;
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_explicit,
  input logic [IDX_W-1:0] ins_index,
  input logic             lk_valid,
  input logic             lk_probe,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic             dm_valid,
  input logic [1:0]       dm_kind,
  input logic [IDX_W-1:0] rd_index,
  input logic [63:0]      rd_tag,
  input logic [63:0]      rd_pte,
  input logic [N-1:0]     used_bits,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     lock_vec,
  input logic [N-1:0]     kill_vec,
  input logic [IDX_W-1:0] victim_idx
);
  // R2
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[lk_idx]);

  // R5
  explicit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_explicit && (int'(ins_index) < N) |=> valid_q[$past(ins_index)]);

  // R6
  all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_explicit && (&valid_q) && (&lock_vec) && (kill_vec == '0)
      |-> victim_idx == IDX_W'(N - 1));

  // R7
  used_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_bits != {N{1'b1}});

  // R7
  used_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used_bits & ~valid_q) == '0);

  // R8
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_probe && !ins_valid && !dm_valid |=> $stable(used_bits));

  // R11
  locked_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid && !ins_valid && (dm_kind == 2'd2)
      |=> ($past(valid_q & lock_vec) & ~valid_q) == '0);

  // R12
  empty_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_index) < N) && !valid_q[rd_index] |-> (rd_tag == '1) && (rd_pte == '1));
endmodule

bind ptlb_array ptlb_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_valid    (ins_valid),
  .ins_explicit (ins_explicit),
  .ins_index    (ins_index),
  .lk_valid     (lk_valid),
  .lk_probe     (lk_probe),
  .lk_hit       (lk_hit),
  .lk_idx       (lk_idx),
  .dm_valid     (dm_valid),
  .dm_kind      (dm_kind),
  .rd_index     (rd_index),
  .rd_tag       (rd_tag),
  .rd_pte       (rd_pte),
  .used_bits    (used_bits),
  .valid_q      (valid_q),
  .lock_vec     (lock_vec),
  .kill_vec     (kill_vec),
  .victim_idx   (victim_idx)
);

// File: tb/ptlb_array_tb.sv
module ptlb_array_tb;
  localparam int N     = 8;
  localparam int VA_W  = 40;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic             rst_n;
  logic             ins_valid, ins_explicit, ins_phys;
  logic [IDX_W-1:0] ins_index;
  logic [VA_W-1:0]  ins_va;
  logic [2:0]       ins_part;
  logic [12:0]      ins_ctx;
  logic [63:0]      ins_pte;
  logic             lk_valid, lk_probe, lk_phys;
  logic [VA_W-1:0]  lk_va;
  logic [2:0]       lk_part;
  logic [12:0]      lk_ctx;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [63:0]      lk_pte;
  logic             dm_valid, dm_phys;
  logic [1:0]       dm_kind;
  logic [VA_W-1:0]  dm_va;
  logic [2:0]       dm_part;
  logic [12:0]      dm_ctx;
  logic [IDX_W-1:0] rd_index;
  logic [63:0]      rd_tag, rd_pte;
  logic [N-1:0]     used_bits;

  ptlb_array #(.N(N), .VA_W(VA_W)) u_dut (.*);

  typedef struct {
    string       req;
    int          field;   // 0 tag, 1 pte, 2 hit, 3 idx, 4 used, 5 lookup pte
    logic [63:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] obs;
        it = q.pop_front();
        case (it.field)
          0: obs = rd_tag;
          1: obs = rd_pte;
          2: obs = 64'(lk_hit);
          3: obs = 64'(lk_idx);
          4: obs = 64'(used_bits);
          default: obs = lk_pte;
        endcase
        n_chk++;
        if (obs !== it.exp) begin
          n_err++;
          $display("FAIL %s field=%0d actual=%h expected=%h", it.req, it.field, obs, it.exp);
        end
      end
    end
  end

  function automatic logic [63:0] etag(logic [VA_W-1:0] va, logic [2:0] part,
                                       logic [12:0] ctx, logic phys, logic [2:0] sz);
    logic [63:0] a;
    logic [2:0]  inv;
    int sh;
    sh  = 13 + 3 * int'(sz);
    a   = (64'(va) >> sh) << sh;
    inv = ~sz;
    return (64'(part) << 61) | (64'(phys) << 60) | (64'(inv) << 56) | a | 64'(ctx);
  endfunction

  function automatic logic [63:0] mkpte(logic [2:0] sz, logic lk, logic [56:0] pay);
    return {pay, lk, 3'b000, sz};
  endfunction

  task automatic push(string req, int field, logic [63:0] exp);
    item_t it;
    it.req = req; it.field = field; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #2;
    ins_valid = 0; dm_valid = 0; lk_valid = 0; lk_probe = 0; ins_explicit = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0;
    ins_valid = 0; dm_valid = 0; lk_valid = 0; lk_probe = 0; ins_explicit = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic set_ins(logic ex, int idx, logic [VA_W-1:0] va, logic [2:0] part,
                         logic [12:0] ctx, logic phys, logic [63:0] pte);
    ins_valid = 1; ins_explicit = ex; ins_index = IDX_W'(idx); ins_va = va;
    ins_part = part; ins_ctx = ctx; ins_phys = phys; ins_pte = pte;
  endtask

  task automatic ins(logic ex, int idx, logic [VA_W-1:0] va, logic [2:0] part,
                     logic [12:0] ctx, logic phys, logic [63:0] pte);
    step();
    set_ins(ex, idx, va, part, ctx, phys, pte);
  endtask

  task automatic set_dm(logic [1:0] kind, logic [VA_W-1:0] va, logic [2:0] part,
                        logic [12:0] ctx, logic phys);
    dm_valid = 1; dm_kind = kind; dm_va = va; dm_part = part; dm_ctx = ctx; dm_phys = phys;
  endtask

  task automatic dmap(logic [1:0] kind, logic [VA_W-1:0] va, logic [2:0] part,
                      logic [12:0] ctx, logic phys);
    step();
    set_dm(kind, va, part, ctx, phys);
  endtask

  task automatic look(string req, logic [VA_W-1:0] va, logic [2:0] part, logic [12:0] ctx,
                      logic phys, logic probe, logic eh, int ei, logic [63:0] ep);
    step();
    lk_valid = 1; lk_probe = probe; lk_va = va; lk_part = part; lk_ctx = ctx; lk_phys = phys;
    push(req, 2, 64'(eh));
    if (eh) begin
      push(req, 3, 64'(ei));
      push(req, 5, ep);
    end
  endtask

  task automatic chk_ent(string req, int idx, logic [63:0] et, logic [63:0] ep);
    step();
    rd_index = IDX_W'(idx);
    push(req, 0, et);
    push(req, 1, ep);
  endtask

  task automatic chk_tag(string req, int idx, logic [63:0] et);
    step();
    rd_index = IDX_W'(idx);
    push(req, 0, et);
  endtask

  task automatic chk_used(string req, logic [N-1:0] e);
    step();
    push(req, 4, 64'(e));
  endtask

  localparam logic [63:0] ONES = '1;

  logic [63:0] p0, p1, p2, p3, p4, px;

  initial begin
    rst_n = 0;
    ins_valid = 0; ins_explicit = 0; ins_index = '0; ins_va = '0; ins_part = '0;
    ins_ctx = '0; ins_phys = 0; ins_pte = '0;
    lk_valid = 0; lk_probe = 0; lk_va = '0; lk_part = '0; lk_ctx = '0; lk_phys = 0;
    dm_valid = 0; dm_kind = '0; dm_va = '0; dm_part = '0; dm_ctx = '0; dm_phys = 0;
    rd_index = '0;

    // ---- R1 / R12: reset state
    do_reset();
    for (int i = 0; i < N; i++) chk_ent("R1 R12 empty after reset", i, ONES, ONES);
    chk_used("R1 used clear", '0);
    look("R1 lookup misses", 40'h12_3456_7ABC, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 0, '0);

    // ---- R3 / R5: inserts into empty slots
    p0 = mkpte(3'd0, 1'b0, 57'hA1);
    ins(0, 0, 40'h12_3456_7ABC, 3'd1, 13'd5, 1'b0, p0);
    chk_ent("R3 aligned tag and data word", 0, etag(40'h12_3456_6000, 1, 5, 0, 0), p0);
    chk_used("R7 insert sets used", 8'h01);
    p1 = mkpte(3'd1, 1'b0, 57'hB2);
    ins(0, 0, 40'h20_0000, 3'd1, 13'd9, 1'b1, p1);
    chk_ent("R5 lowest free slot", 1, etag(40'h20_0000, 1, 9, 1, 1), p1);
    p2 = mkpte(3'd2, 1'b0, 57'hC3);
    ins(0, 0, 40'h40_0000, 3'd1, 13'd5, 1'b0, p2);
    chk_used("R7 used accumulates", 8'h07);

    // ---- R2 / R8: lookups
    look("R2 R8 probe hit", 40'h12_3456_7FFF, 3'd1, 13'd5, 1'b0, 1'b1, 1'b1, 0, p0);
    chk_used("R8 probe leaves used", 8'h07);
    look("R2 real ignores context", 40'h20_FFFF, 3'd1, 13'h1FFF, 1'b1, 1'b0, 1'b1, 1, p1);
    look("R2 context mismatch", 40'h12_3456_7000, 3'd1, 13'd6, 1'b0, 1'b0, 1'b0, 0, '0);
    look("R2 real flag mismatch", 40'h12_3456_7000, 3'd1, 13'd5, 1'b1, 1'b0, 1'b0, 0, '0);
    look("R2 partition mismatch", 40'h12_3456_7000, 3'd2, 13'd5, 1'b0, 1'b0, 1'b0, 0, '0);
    look("R2 large page top", 40'h47_FFFF, 3'd1, 13'd5, 1'b0, 1'b0, 1'b1, 2, p2);
    look("R2 large page beyond", 40'h48_0000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 0, '0);

    // ---- R4: overlap invalidation
    p3 = mkpte(3'd0, 1'b0, 57'hD4);
    ins(0, 0, 40'h41_0000, 3'd2, 13'd5, 1'b0, p3);
    chk_tag("R4 other partition kept", 2, etag(40'h40_0000, 1, 5, 0, 2));
    p4 = mkpte(3'd0, 1'b0, 57'hE5);
    ins(0, 0, 40'h41_2000, 3'd1, 13'd5, 1'b0, p4);
    chk_ent("R4 R5 overlapped slot reused", 2, etag(40'h41_2000, 1, 5, 0, 0), p4);
    look("R4 big page removed", 40'h40_0000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b0, 0, '0);
    chk_used("R7 used after overlap", 8'h0F);

    // ---- R7: fill and wrap of used bits
    for (int k = 0; k < 4; k++)
      ins(0, 0, 40'h100_0000 + 40'(k) * 40'h2000, 3'd3, 13'(k + 1), 1'b0,
          mkpte(3'd0, (k == 1 || k == 2), 57'(k)));
    chk_used("R7 wrap keeps only touched", 8'h80);
    look("R7 lookup hit sets used", 40'h12_3456_6000, 3'd1, 13'd5, 1'b0, 1'b0, 1'b1, 0, p0);
    chk_used("R7 lookup set", 8'h81);
    look("R8 probe", 40'h20_0000, 3'd1, 13'd0, 1'b1, 1'b1, 1'b1, 1, p1);
    chk_used("R8 probe leaves used", 8'h81);

    // ---- R9 / R10 / R11: demaps
    dmap(2'd3, 40'h12_3456_6000, 3'd1, 13'd5, 1'b0);
    chk_tag("R11 code 3 no effect", 0, etag(40'h12_3456_6000, 1, 5, 0, 0));
    dmap(2'd0, 40'h12_3456_6100, 3'd1, 13'd5, 1'b0);
    chk_ent("R9 page demap", 0, ONES, ONES);
    chk_used("R7 demap clears used", 8'h80);
    dmap(2'd1, '0, 3'd1, 13'd5, 1'b0);
    chk_tag("R10 context demap", 2, ONES);
    chk_tag("R10 other context kept", 1, etag(40'h20_0000, 1, 9, 1, 1));
    dmap(2'd2, '0, 3'd3, 13'd0, 1'b0);
    chk_tag("R11 unlocked removed", 4, ONES);
    chk_tag("R11 locked kept", 5, etag(40'h100_2000, 3, 2, 0, 0));
    chk_tag("R11 locked kept", 6, etag(40'h100_4000, 3, 3, 0, 0));
    chk_tag("R11 unlocked removed", 7, ONES);

    // ---- R13: insert wins over demap
    step();
    px = mkpte(3'd0, 1'b0, 57'hF6);
    set_ins(0, 0, 40'h50_0000, 3'd1, 13'd5, 1'b0, px);
    set_dm(2'd2, '0, 3'd2, 13'd0, 1'b0);
    chk_tag("R13 demap ignored", 3, etag(40'h41_0000, 2, 5, 0, 0));
    chk_ent("R13 insert done", 0, etag(40'h50_0000, 1, 5, 0, 0), px);
    chk_used("R13 used", 8'h01);

    // ---- R5 / R6: explicit index and rotating victim
    do_reset();
    ins(1, 5, 40'h3000_0000, 3'd0, 13'd0, 1'b0, mkpte(3'd0, 1'b0, 57'h5));
    chk_tag("R5 explicit index", 5, etag(40'h3000_0000, 0, 0, 0, 0));
    begin
      int slots[7] = '{0, 1, 2, 3, 4, 6, 7};
      for (int j = 0; j < 7; j++)
        ins(0, 0, 40'h1000_0000 + 40'(j) * 40'h2000, 3'd0, 13'd0, 1'b0,
            mkpte(3'd0, (slots[j] == 1 || slots[j] == 2), 57'(j)));
    end
    chk_used("R7 wrap on fill", 8'h80);
    ins(0, 0, 40'h2000_0000, 3'd0, 13'd0, 1'b0, mkpte(3'd0, 1'b0, 57'h77));
    chk_tag("R6 scan skips locked", 3, etag(40'h2000_0000, 0, 0, 0, 0));
    chk_tag("R6 locked untouched", 1, etag(40'h1000_2000, 0, 0, 0, 0));
    chk_used("R7 used after scan insert", 8'h88);
    ins(0, 0, 40'h2000_2000, 3'd0, 13'd0, 1'b0, mkpte(3'd0, 1'b0, 57'h78));
    chk_tag("R6 pointer advanced", 4, etag(40'h2000_2000, 0, 0, 0, 0));

    // ---- R6: all locked
    do_reset();
    for (int j = 0; j < N; j++)
      ins(0, 0, 40'h1000_0000 + 40'(j) * 40'h2000, 3'd0, 13'd0, 1'b0,
          mkpte(3'd0, 1'b1, 57'(j)));
    ins(0, 0, 40'h5000_0000, 3'd0, 13'd0, 1'b0, mkpte(3'd0, 1'b0, 57'h99));
    chk_tag("R6 all locked uses last", 7, etag(40'h5000_0000, 0, 0, 0, 0));
    chk_tag("R6 others kept", 6, etag(40'h1000_C000, 0, 0, 0, 0));

    step();
    step();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule